// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Controller

This block collects interrupt requests from a fixed set of peripheral sources (fourteen by default) in a small processor subsystem and presents the processor with a single maskable request. Each source owns an 8-bit control register on a simple register bus. The register holds a 3-bit priority level, where zero disables the source, and a pending flag. Hardware sets the flag when the source pulses its event line. Software can clear the flag but never set it.

Every cycle the block picks the pending, enabled source with the highest level. Ties go to the lowest source index. The block raises its request only when the global interrupt enable is high and the winning level is strictly above the processor's current priority level. The request output, winner index and winner level are registered. When the processor acknowledges the request, the winner's pending flag clears automatically.

One source slot is shared between two peripheral events. A separate select register chooses which of the two events feeds that slot.

Top module: `irq_ctl`

## Requirements
- R1: Bits 2..0 of control register k (bus address k, 0 to 13) hold the priority level of source k. The bits are written and read back unchanged. A source whose level is 0 never wins and never raises `irq_o`.
- R2: A 1 on the effective event of source k in a cycle sets the pending flag, bit 3 of control register k, from the next cycle on.
- R3: A bus write to control register k with bit 3 at 0 clears the pending flag. A write with bit 3 at 1 leaves the flag unchanged.
- R4: After reset every control register and the select register read 0, and `irq_o`, `irq_id_o` and `irq_lvl_o` are 0.
- R5: Bits 7..4 of every control register, and bits 7..1 of the select register, ignore writes and read as 0.
- R6: `irq_o` is 1 only when `ien_i` is 1 and the winning level is strictly greater than `ipl_i`.
- R7: Among pending sources with a non-zero level, the highest level wins. When levels are equal, the lowest index wins.
- R8: A cycle with `irq_ack_i` at 1 while `irq_o` is 1 clears the pending flag of source `irq_id_o`.
- R9: When a hardware event for a source arrives in the same cycle as a software clear or an acknowledge clear of that source, the flag ends at 1.
- R10: Bit 0 of the select register (bus address 14) chooses the event for source 0. At 0, source 0 takes `evt_i[0]`. At 1, it takes `alt_evt_i`, and `evt_i[0]` has no effect.
- R11: The outputs are registered. They reflect the register state and the `ien_i`/`ipl_i` values of the previous cycle, so a bus write, an event, an acknowledge or a change of enable or priority shows on the outputs one cycle later. When `irq_o` is 0, `irq_id_o` and `irq_lvl_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr_i | input | 4 | Register address: 0..13 control registers, 14 select register |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| evt_i | input | 14 | Event pulses, one per source |
| alt_evt_i | input | 1 | Alternative event for the shared source 0 |
| ien_i | input | 1 | Global maskable interrupt enable |
| ipl_i | input | 3 | Processor current priority level |
| irq_ack_i | input | 1 | Processor acknowledge of the presented request |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | 4 | Index of the winning source |
| irq_lvl_o | output | 3 | Level of the winning source |

## Verification
Two pairs of functions can land on the same pending flag in the same cycle. One pair is a peripheral event and a software clear. The other is a peripheral event and an acknowledge clear of the presented winner. The bench forces both collisions deliberately: it pulses a source's event while writing 0 to its flag bit, and while acknowledging that same source. It then reads the flag back and checks it is still 1. A random phase with dense writes, events and acknowledges repeats these collisions many times. A behavioural model compares flags, levels and outputs on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned LVL_W    = 3;
  parameter int unsigned REG_W    = 8;
  parameter int unsigned FLAG_BIT = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_evt_sel.sv
module irq_evt_sel #(
  parameter int unsigned NUM_SRC     = 14,
  parameter int unsigned SHARED_SLOT = 0
) (
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               alt_evt_i,
  input  logic               sel_i,
  output logic [NUM_SRC-1:0] evt_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    if (g == SHARED_SLOT) begin : g_shared
      assign evt_o[g] = sel_i ? alt_evt_i : evt_i[g];
    end else begin : g_plain
      assign evt_o[g] = evt_i[g];
    end
  end
endmodule

// File: rtl/irq_src_reg.sv
module irq_src_reg
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_i,
  input  logic       wr_i,
  input  logic [3:0] wdata_i,
  input  logic       ack_clr_i,
  output lvl_t       lvl_o,
  output logic       flag_o,
  output lvl_t       lvl_nxt_o,
  output logic       flag_nxt_o
);
  lvl_t lvl_q, lvl_d;
  logic flag_q, flag_d;
  logic sw_clr;

  always_comb begin
    sw_clr = wr_i && !wdata_i[FLAG_BIT];
    lvl_d  = wr_i ? wdata_i[LVL_W-1:0] : lvl_q;
    if (evt_i)                  flag_d = 1'b1;
    else if (sw_clr || ack_clr_i) flag_d = 1'b0;
    else                        flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      flag_q <= flag_d;
    end
  end

  assign lvl_o      = lvl_q;
  assign flag_o     = flag_q;
  assign lvl_nxt_o  = lvl_d;
  assign flag_nxt_o = flag_d;

  // R2 R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_q);

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !evt_i) |=> !flag_q);
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 14,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic                          ien_i,
  input  lvl_t                          ipl_i,
  output logic                          hit_o,
  output logic [ID_W-1:0]               id_o,
  output lvl_t                          lvl_o
);
  lvl_t            best_lvl;
  logic [ID_W-1:0] best_id;

  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pend_i[k] && (lvl_i[k] != '0) && (lvl_i[k] >= best_lvl)) begin
        best_lvl = lvl_i[k];
        best_id  = ID_W'(k);
      end
    end
    hit_o = ien_i && (best_lvl > ipl_i);
    id_o  = hit_o ? best_id  : '0;
    lvl_o = hit_o ? best_lvl : '0;
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 14,
  parameter int unsigned SHARED_SLOT = 0,
  localparam int unsigned ID_W       = $clog2(NUM_SRC),
  localparam int unsigned ADDR_W     = $clog2(NUM_SRC + 1),
  localparam int unsigned SEL_ADDR   = NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic [REG_W-1:0]   bus_wdata_i,
  output logic [REG_W-1:0]   bus_rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               alt_evt_i,
  input  logic               ien_i,
  input  logic [LVL_W-1:0]   ipl_i,
  input  logic               irq_ack_i,
  output logic               irq_o,
  output logic [ID_W-1:0]    irq_id_o,
  output logic [LVL_W-1:0]   irq_lvl_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // select register for the shared slot
  logic sel_q, sel_d, sel_wr;
  assign sel_wr = bus_wr_i && (bus_addr_i == ADDR_W'(SEL_ADDR));

  always_comb begin
    sel_d = sel_wr ? bus_wdata_i[0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sel_q <= 1'b0;
    else            sel_q <= sel_d;
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata_i[REG_W-1:4];

  // event routing
  logic [NUM_SRC-1:0] evt_eff;

  irq_evt_sel #(.NUM_SRC(NUM_SRC), .SHARED_SLOT(SHARED_SLOT)) u_evt_sel (
    .evt_i     (evt_i),
    .alt_evt_i (alt_evt_i),
    .sel_i     (sel_q),
    .evt_o     (evt_eff)
  );

  // per-source control registers
  logic [NUM_SRC-1:0]            flag_q, flag_nxt;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q, lvl_nxt;
  logic                          ack_take;
  assign ack_take = irq_ack_i && irq_o;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic wr_hit, ack_hit;
    assign wr_hit  = bus_wr_i && (bus_addr_i == ADDR_W'(g));
    assign ack_hit = ack_take && (irq_id_o == ID_W'(g));

    irq_src_reg u_reg (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .evt_i      (evt_eff[g]),
      .wr_i       (wr_hit),
      .wdata_i    (bus_wdata_i[3:0]),
      .ack_clr_i  (ack_hit),
      .lvl_o      (lvl_q[g]),
      .flag_o     (flag_q[g]),
      .lvl_nxt_o  (lvl_nxt[g]),
      .flag_nxt_o (flag_nxt[g])
    );
  end

  // arbitration on next-state values so outputs track the registers
  logic            hit_d;
  logic [ID_W-1:0] id_d;
  lvl_t            lvl_d;

  irq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i (flag_nxt),
    .lvl_i  (lvl_nxt),
    .ien_i  (ien_i),
    .ipl_i  (ipl_i),
    .hit_o  (hit_d),
    .id_o   (id_d),
    .lvl_o  (lvl_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_o     <= 1'b0;
      irq_id_o  <= '0;
      irq_lvl_o <= '0;
    end else begin
      irq_o     <= hit_d;
      irq_id_o  <= id_d;
      irq_lvl_o <= lvl_d;
    end
  end

  // register read mux
  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(SEL_ADDR)) begin
      bus_rdata_o[0] = sel_q;
    end
    for (int k = 0; k < NUM_SRC; k++) begin
      if (bus_addr_i == ADDR_W'(k)) begin
        bus_rdata_o = {4'b0000, flag_q[k], lvl_q[k]};
      end
    end
  end

  // R1
  no_zero_level_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (irq_lvl_o != '0));

  // R6
  ien_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> $past(ien_i));

  // R6
  ipl_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (irq_lvl_o > $past(ipl_i)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_ack_i && irq_o && !evt_eff[irq_id_o]) |=> !flag_q[$past(irq_id_o)]);

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !irq_o |-> (irq_id_o == '0 && irq_lvl_o == '0));
endmodule

// File: tb/sim_irq_ctl.sv
`timescale 1ns/1ps
module sim_irq_ctl;
  localparam int N = 14;
  localparam int SEL_A = 14;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [N-1:0] evt;
  logic       alt;
  logic       ien;
  logic [2:0] ipl;
  logic       ack;
  logic       irq;
  logic [3:0] irq_id;
  logic [2:0] irq_lvl;

  always #5 clk = ~clk;

  irq_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt), .alt_evt_i(alt),
    .ien_i(ien), .ipl_i(ipl), .irq_ack_i(ack), .irq_o(irq),
    .irq_id_o(irq_id), .irq_lvl_o(irq_lvl)
  );

  int nchk = 0;
  int nbad = 0;
  int m_lvl [N];
  int m_flg [N];
  int m_sel = 0;
  int m_irq = 0, m_id = 0, m_ilv = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_read(input int a);
    if (a == SEL_A) return m_sel;
    if (a < N) return m_flg[a] * 8 + m_lvl[a];
    return 0;
  endfunction

  // one clock: model update from present inputs, then compare every output
  task automatic step();
    int nf [N];
    int nl [N];
    int ns, e, clr, bl, bi, ni;
    for (int i = 0; i < N; i++) begin
      e   = (i == 0) ? (m_sel != 0 ? int'(alt) : int'(evt[0])) : int'(evt[i]);
      clr = ((wr && addr == i && !wdata[3]) || (ack && m_irq != 0 && m_id == i)) ? 1 : 0;
      nf[i] = e ? 1 : (clr ? 0 : m_flg[i]);
      nl[i] = (wr && addr == i) ? int'(wdata[2:0]) : m_lvl[i];
    end
    ns = (wr && addr == SEL_A) ? int'(wdata[0]) : m_sel;
    bl = 0; bi = 0;
    for (int i = 0; i < N; i++)
      if (nf[i] != 0 && nl[i] > bl) begin bl = nl[i]; bi = i; end
    ni = (ien && bl > int'(ipl)) ? 1 : 0;
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin m_flg[i] = nf[i]; m_lvl[i] = nl[i]; end
    m_sel = ns;
    m_irq = ni; m_id = ni ? bi : 0; m_ilv = ni ? bl : 0;
    // R6 R7 R11 compared every clock
    chk(int'(irq) == m_irq, "R6 irq", int'(irq), m_irq);
    chk(int'(irq_id) == m_id, "R7 id", int'(irq_id), m_id);
    chk(int'(irq_lvl) == m_ilv, "R11 lvl", int'(irq_lvl), m_ilv);
    chk(int'(rdata) == m_read(int'(addr)), "R11 rdata", int'(rdata), m_read(int'(addr)));
  endtask

  task automatic wreg(input int a, input int d);
    addr = 4'(a); wr = 1'b1; wdata = 8'(d);
    step();
    wr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string req);
    addr = 4'(a);
    #1;
    chk(int'(rdata) == exp, req, int'(rdata), exp);
  endtask

  task automatic pulse(input int i);
    evt[i] = 1'b1;
    step();
    evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_flg[i] = 0; end
    rst_n = 1'b0; addr = '0; wr = 1'b0; wdata = '0; evt = '0;
    alt = 1'b0; ien = 1'b0; ipl = '0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) step();

    // R4: reset state
    for (int a = 0; a <= SEL_A; a++) rd(a, 0, "R4 reset reg");
    chk(irq == 1'b0, "R4 irq", int'(irq), 0);

    // R1 R5: level write, upper bits ignored
    wreg(3, 8'hF5);
    rd(3, 5, "R1 R5 level readback");
    wreg(SEL_A, 8'hFE);
    rd(SEL_A, 0, "R5 select upper bits");
    // R3: writing 1 to flag does not set it
    wreg(4, 8'h0D);
    rd(4, 5, "R3 write one no set");

    // R2: event sets flag, R6 request appears
    ien = 1'b1; ipl = 3'd0;
    pulse(3);
    rd(3, 13, "R2 flag set");
    step();
    chk(irq == 1'b1 && irq_id == 4'd3, "R6 irq raised", int'(irq_id), 3);

    // R7: tie at level 5, lowest index wins
    pulse(4);
    chk(irq_id == 4'd3, "R7 tie lowest index", int'(irq_id), 3);
    wreg(7, 6);
    pulse(7);
    chk(irq_id == 4'd7 && irq_lvl == 3'd6, "R7 highest level", int'(irq_id), 7);

    // R6: masking by ipl and enable
    ipl = 3'd6; step();
    chk(irq == 1'b0, "R6 ipl equal masks", int'(irq), 0);
    ipl = 3'd0; ien = 1'b0; step();
    chk(irq == 1'b0, "R6 ien masks", int'(irq), 0);
    ien = 1'b1; step();

    // R8: acknowledge clears winner
    ack = 1'b1; step(); ack = 1'b0;
    rd(7, 6, "R8 ack cleared");
    step();
    chk(irq_id == 4'd3, "R8 next winner", int'(irq_id), 3);

    // R9: event beats software clear
    evt[3] = 1'b1; wreg(3, 8'h05); evt = '0;
    rd(3, 13, "R9 set beats sw clear");
    // R9: event beats acknowledge clear of the winner (source 3)
    step();
    evt[3] = 1'b1; ack = 1'b1; step(); evt = '0; ack = 1'b0;
    rd(3, 13, "R9 set beats ack clear");

    // clear everything
    for (int i = 0; i < N; i++) wreg(i, 0);
    step();
    chk(irq == 1'b0, "R3 clears drop irq", int'(irq), 0);

    // R10: shared slot select
    wreg(0, 2);
    alt = 1'b1; step(); alt = 1'b0;
    rd(0, 2, "R10 alt ignored when sel 0");
    pulse(0);
    rd(0, 10, "R10 evt0 when sel 0");
    wreg(0, 2);
    wreg(SEL_A, 1);
    rd(SEL_A, 1, "R10 select readback");
    pulse(0);
    rd(0, 2, "R10 evt0 ignored when sel 1");
    alt = 1'b1; step(); alt = 1'b0;
    rd(0, 10, "R10 alt sets when sel 1");

    // R1: level 0 never wins
    for (int i = 0; i < N; i++) wreg(i, 0);
    pulse(5); step();
    rd(5, 8, "R1 pending at level 0");
    chk(irq == 1'b0, "R1 level 0 no irq", int'(irq), 0);

    // random traffic, checked each clock by the model (R11)
    for (int c = 0; c < 3000; c++) begin
      wr    = ($urandom_range(0, 3) == 0);
      addr  = 4'($urandom_range(0, 15));
      wdata = 8'($urandom);
      evt   = N'($urandom) & N'($urandom) & N'($urandom);
      alt   = 1'($urandom);
      ien   = ($urandom_range(0, 7) != 0);
      ipl   = 3'($urandom_range(0, 7)) & 3'($urandom);
      ack   = (m_irq != 0) && ($urandom_range(0, 2) == 0);
      step();
    end
    wr = 1'b0; ack = 1'b0; evt = '0;
    step();

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule